// File: doc/BRIEF.md
# Acknowledged-link packet framer and serializer

This block turns one outgoing radio packet into a serial bit stream, one bit per clock. A start strobe takes a snapshot of the receiver address and its width, the payload bytes and their count, a two-bit packet identifier, a flag asking the receiver not to acknowledge, and a choice of checksum width. The block then sends the fields in this order: a one-byte preamble, the address, a nine-bit control field, the payload and the checksum.

The control field is nine bits wide, so it is not aligned to a byte. It holds the payload length, the packet identifier and the no-acknowledge flag. The caller keeps the identifier unchanged when it retries a packet and advances it for a new packet. The receiver uses it to recognise a repeated packet. The checksum is computed bit by bit as the protected fields go out, and it is appended in the same cycle stream with no gap. Modulation and the receive path sit outside this block.

Top module: `pkt_framer`

## Requirements
- R1: The block accepts `start_i` only on a clock edge where `valid_o` is low. `valid_o` is high in the next cycle, carrying the first preamble bit. It then stays high for exactly 8 + 8·A + 9 + 8·L + 8·C consecutive cycles, with one bit on `bit_o` per cycle. A is the address byte count, L the payload byte count and C the checksum byte count.
- R2: The preamble is 0xAA when the first address bit sent is 1, and 0x55 when it is 0. It is sent most significant bit first.
- R3: A is `addr_bytes_i` held to the range 3 to 5: values below 3 give 3 and values above 5 give 5. The address bits sent are `addr_i[8A-1]` down to `addr_i[0]`.
- R4: The control field is sent as nine bits, most significant first: a 6-bit length, then `pid_i[1:0]`, then `no_ack_i`. The length is L, where L is `len_i` limited to a maximum of 32.
- R5: Payload byte k is `payload_i[8k+7:8k]`. Byte 0 is sent first and each byte goes most significant bit first. When L is 0, the first checksum bit follows the last control bit directly.
- R6: With `crc_two_i`=1, C is 2. The checksum is CRC-16 with polynomial 0x1021 and start value 0xFFFF, taken over the address, control and payload bits in the order they are sent, with no final inversion. It is sent most significant bit first.
- R7: With `crc_two_i`=0, C is 1. The checksum is CRC-8 with polynomial 0x07 and start value 0xFF, taken over the same bits and sent the same way.
- R8: `done_o` is high only in the cycle that carries the last checksum bit.
- R9: A start strobe while `valid_o` is high is ignored, and that includes the last bit's cycle. Input changes during a frame do not alter that frame.
- R10: During and after reset, and whenever no frame is being sent, `valid_o`, `bit_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken when idle |
| addr_i | input | 40 | Receiver address, right-aligned |
| addr_bytes_i | input | 3 | Address byte count (3 to 5) |
| len_i | input | 6 | Payload byte count (0 to 32) |
| pid_i | input | 2 | Packet identifier |
| no_ack_i | input | 1 | 1: receiver must not acknowledge |
| crc_two_i | input | 1 | 1: two-byte checksum, 0: one byte |
| payload_i | input | 256 | Payload bytes, byte 0 in the low bits |
| bit_o | output | 1 | Serial data bit |
| valid_o | output | 1 | `bit_o` carries a frame bit |
| done_o | output | 1 | Last bit of the frame |

## Verification
The bench builds the block with its default limits of five address bytes and 32 payload bytes. This brings every legal address width, the zero-length payload and the full 32-byte payload within reach. It also covers out-of-range address counts and lengths, which the block must clamp. Frames are sent singly, back to back with the strobe held high, and with stray strobes and changing inputs during a frame. Both checksum widths are used with preambles of both polarities.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_ADDR, PH_CTRL, PH_PLD, PH_CRC
  } phase_e;

  localparam int            LEN_W    = 6;
  localparam int            CTRL_W   = LEN_W + 3;
  localparam logic [15:0]   POLY_W   = 16'h1021;
  localparam logic [7:0]    POLY_N   = 8'h07;
  localparam logic [15:0]   SEED_W   = 16'hFFFF;
  localparam logic [7:0]    SEED_N   = 8'hFF;
endpackage

// File: rtl/pf_crc.sv
module pf_crc
  import pf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_i,
  input  logic wide_i,
  input  logic upd_i,
  input  logic shift_i,
  input  logic din_i,
  output logic msb_o
);
  logic [15:0] rem_q, rem_n;
  logic        wide_q, wide_n;
  logic        fb;

  assign msb_o = wide_q ? rem_q[15] : rem_q[7];
  assign fb    = msb_o ^ din_i;

  always_comb begin
    rem_n  = rem_q;
    wide_n = wide_q;
    if (init_i) begin
      wide_n = wide_i;
      rem_n  = wide_i ? SEED_W : {8'h00, SEED_N};
    end else if (upd_i) begin
      if (wide_q) rem_n = {rem_q[14:0], 1'b0} ^ (fb ? POLY_W : 16'h0000);
      else        rem_n = {8'h00, {rem_q[6:0], 1'b0} ^ (fb ? POLY_N : 8'h00)};
    end else if (shift_i) begin
      if (wide_q) rem_n = {rem_q[14:0], 1'b0};
      else        rem_n = {8'h00, rem_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      wide_q <= 1'b0;
    end else if (init_i || upd_i || shift_i) begin
      rem_q  <= rem_n;
      wide_q <= wide_n;
    end
  end

  // R7: the narrow remainder never leaks into the upper byte
  a_r7_narrow_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |-> rem_q[15:8] == 8'h00);
endmodule

// File: rtl/pf_seq.sv
module pf_seq
  import pf_pkg::*;
#(
  parameter int ADDR_MIN = 3,
  parameter int ADDR_MAX = 5,
  parameter int PLD_MAX  = 32,
  localparam int AW      = $clog2(ADDR_MAX + 1),
  localparam int IDXW    = $clog2(8 * PLD_MAX),
  localparam int FBW     = IDXW + 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    abytes_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             crc2_i,
  output phase_e           phase_o,
  output logic [IDXW-1:0]  idx_o,
  output logic [AW-1:0]    abytes_o,
  output logic [LEN_W-1:0] plen_o,
  output logic             load_o,
  output logic             done_o
);
  phase_e           phase_q, phase_n;
  logic [IDXW-1:0]  idx_q, idx_n;
  logic [AW-1:0]    abytes_q, abytes_c;
  logic [LEN_W-1:0] plen_q, plen_c;
  logic             crc2_q;
  logic [FBW-1:0]   fbits;
  logic             last;

  assign abytes_c = (int'(abytes_i) < ADDR_MIN) ? AW'(ADDR_MIN) :
                    (int'(abytes_i) > ADDR_MAX) ? AW'(ADDR_MAX) : abytes_i;
  assign plen_c   = (int'(len_i) > PLD_MAX) ? LEN_W'(PLD_MAX) : len_i;
  assign load_o   = (phase_q == PH_IDLE) && start_i;

  always_comb begin
    case (phase_q)
      PH_PRE:  fbits = FBW'(8);
      PH_ADDR: fbits = FBW'(int'(abytes_q) * 8);
      PH_CTRL: fbits = FBW'(CTRL_W);
      PH_PLD:  fbits = FBW'(int'(plen_q) * 8);
      PH_CRC:  fbits = crc2_q ? FBW'(16) : FBW'(8);
      default: fbits = FBW'(0);
    endcase
  end

  assign last = (phase_q != PH_IDLE) && ({1'b0, idx_q} + FBW'(1) == fbits);

  always_comb begin
    phase_n = phase_q;
    idx_n   = idx_q;
    if (load_o) begin
      phase_n = PH_PRE;
      idx_n   = '0;
    end else if (phase_q != PH_IDLE) begin
      idx_n = last ? '0 : idx_q + IDXW'(1);
      if (last) begin
        case (phase_q)
          PH_PRE:  phase_n = PH_ADDR;
          PH_ADDR: phase_n = PH_CTRL;
          PH_CTRL: phase_n = (plen_q == '0) ? PH_CRC : PH_PLD;
          PH_PLD:  phase_n = PH_CRC;
          default: phase_n = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_n;
      idx_q   <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abytes_q <= AW'(ADDR_MIN);
      plen_q   <= '0;
      crc2_q   <= 1'b0;
    end else if (load_o) begin
      abytes_q <= abytes_c;
      plen_q   <= plen_c;
      crc2_q   <= crc2_i;
    end
  end

  assign phase_o  = phase_q;
  assign idx_o    = idx_q;
  assign abytes_o = abytes_q;
  assign plen_o   = plen_q;
  assign done_o   = last && (phase_q == PH_CRC);

  // R1: fields follow in frame order
  a_r1_pre_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_PRE |=> phase_q inside {PH_PRE, PH_ADDR});
  a_r1_addr_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_ADDR |=> phase_q inside {PH_ADDR, PH_CTRL});
  a_r1_ctrl_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_CTRL |=> phase_q inside {PH_CTRL, PH_PLD, PH_CRC});
  a_r1_pld_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_PLD |=> phase_q inside {PH_PLD, PH_CRC});
  a_r3_width_legal: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_IDLE |-> (int'(abytes_q) >= ADDR_MIN && int'(abytes_q) <= ADDR_MAX));
  a_r5_no_empty_payload: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_PLD |-> plen_q != '0);
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> phase_q == PH_IDLE);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_IDLE |=> !(phase_q == PH_PRE && idx_q == '0));
endmodule

// File: rtl/pf_bitsel.sv
module pf_bitsel
  import pf_pkg::*;
#(
  parameter int ADDR_MAX = 5,
  parameter int PLD_MAX  = 32,
  localparam int AW      = $clog2(ADDR_MAX + 1),
  localparam int AIXW    = $clog2(8 * ADDR_MAX),
  localparam int IDXW    = $clog2(8 * PLD_MAX)
)(
  input  phase_e                 phase_i,
  input  logic [IDXW-1:0]        idx_i,
  input  logic [AW-1:0]          abytes_i,
  input  logic [8*ADDR_MAX-1:0]  addr_i,
  input  logic [CTRL_W-1:0]      ctrl_i,
  input  logic [8*PLD_MAX-1:0]   pld_i,
  input  logic                   crc_msb_i,
  output logic                   bit_o
);
  logic [AIXW-1:0] aix, atop;
  logic [3:0]      cix;
  logic [IDXW-1:0] pix;
  logic [7:0]      pre;

  assign atop = AIXW'(int'(abytes_i) * 8 - 1);
  assign aix  = AIXW'(int'(abytes_i) * 8 - 1 - int'(idx_i));
  assign cix  = 4'(CTRL_W - 1 - int'(idx_i));
  assign pix  = {idx_i[IDXW-1:3], ~idx_i[2:0]};
  assign pre  = addr_i[atop] ? 8'hAA : 8'h55;

  always_comb begin
    case (phase_i)
      PH_PRE:  bit_o = pre[~idx_i[2:0]];
      PH_ADDR: bit_o = addr_i[aix];
      PH_CTRL: bit_o = ctrl_i[cix];
      PH_PLD:  bit_o = pld_i[pix];
      PH_CRC:  bit_o = crc_msb_i;
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pf_pkg::*;
#(
  parameter int ADDR_MIN = 3,
  parameter int ADDR_MAX = 5,
  parameter int PLD_MAX  = 32,
  localparam int AW      = $clog2(ADDR_MAX + 1),
  localparam int IDXW    = $clog2(8 * PLD_MAX)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [8*ADDR_MAX-1:0] addr_i,
  input  logic [AW-1:0]         addr_bytes_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [1:0]            pid_i,
  input  logic                  no_ack_i,
  input  logic                  crc_two_i,
  input  logic [8*PLD_MAX-1:0]  payload_i,
  output logic                  bit_o,
  output logic                  valid_o,
  output logic                  done_o
);
  phase_e                phase;
  logic [IDXW-1:0]       idx;
  logic [AW-1:0]         abytes;
  logic [LEN_W-1:0]      plen;
  logic                  load, crc_msb, data_bit;
  logic [8*ADDR_MAX-1:0] addr_q;
  logic [8*PLD_MAX-1:0]  pld_q;
  logic [1:0]            pid_q;
  logic                  noack_q;
  logic                  in_crc_span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pld_q   <= '0;
      pid_q   <= '0;
      noack_q <= 1'b0;
    end else if (load) begin
      addr_q  <= addr_i;
      pld_q   <= payload_i;
      pid_q   <= pid_i;
      noack_q <= no_ack_i;
    end
  end

  pf_seq #(.ADDR_MIN(ADDR_MIN), .ADDR_MAX(ADDR_MAX), .PLD_MAX(PLD_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abytes_i(addr_bytes_i),
    .len_i(len_i), .crc2_i(crc_two_i), .phase_o(phase), .idx_o(idx),
    .abytes_o(abytes), .plen_o(plen), .load_o(load), .done_o(done_o)
  );

  pf_bitsel #(.ADDR_MAX(ADDR_MAX), .PLD_MAX(PLD_MAX)) u_sel (
    .phase_i(phase), .idx_i(idx), .abytes_i(abytes), .addr_i(addr_q),
    .ctrl_i({plen, pid_q, noack_q}), .pld_i(pld_q), .crc_msb_i(crc_msb),
    .bit_o(data_bit)
  );

  assign in_crc_span = phase inside {PH_ADDR, PH_CTRL, PH_PLD};

  pf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init_i(load), .wide_i(crc_two_i),
    .upd_i(in_crc_span), .shift_i(phase == PH_CRC), .din_i(data_bit),
    .msb_o(crc_msb)
  );

  assign bit_o   = data_bit;
  assign valid_o = (phase != PH_IDLE);

  // R10: an idle serializer stays quiet
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!bit_o && !done_o));
endmodule

// File: tb/pkt_framer_test.sv
module pkt_framer_test;
  localparam int AM = 5;
  localparam int PM = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [8*AM-1:0] addr_i;
  logic [2:0]    addr_bytes_i;
  logic [5:0]    len_i;
  logic [1:0]    pid_i;
  logic          no_ack_i;
  logic          crc_two_i;
  logic [8*PM-1:0] payload_i;
  logic          bit_o, valid_o, done_o;

  always #4 clk = ~clk;

  pkt_framer #(.ADDR_MAX(AM), .PLD_MAX(PM)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .addr_bytes_i(addr_bytes_i), .len_i(len_i), .pid_i(pid_i),
    .no_ack_i(no_ack_i), .crc_two_i(crc_two_i), .payload_i(payload_i),
    .bit_o(bit_o), .valid_o(valid_o), .done_o(done_o)
  );

  bit    q[$];
  string tq[$];
  int    nchk = 0, nfail = 0;
  bit    ign = 0;
  bit    accepted = 0;

  // Expected frame, per R2..R7
  task automatic build();
    int  a, l;
    bit  d[$];
    bit  first;
    logic [7:0]  pre;
    logic [8:0]  ctl;
    logic [15:0] c;
    bit  fb;
    a = (addr_bytes_i < 3) ? 3 : (addr_bytes_i > 5) ? 5 : int'(addr_bytes_i);
    l = (len_i > 32) ? 32 : int'(len_i);
    first = addr_i[8*a-1];
    pre = first ? 8'hAA : 8'h55;
    for (int i = 7; i >= 0; i--) begin q.push_back(pre[i]); tq.push_back("R2"); end
    for (int i = 8*a-1; i >= 0; i--) begin
      q.push_back(addr_i[i]); tq.push_back("R3"); d.push_back(addr_i[i]);
    end
    ctl = {6'(l), pid_i, no_ack_i};
    for (int i = 8; i >= 0; i--) begin
      q.push_back(ctl[i]); tq.push_back("R4"); d.push_back(ctl[i]);
    end
    for (int k = 0; k < l; k++)
      for (int b = 7; b >= 0; b--) begin
        q.push_back(payload_i[8*k+b]); tq.push_back("R5"); d.push_back(payload_i[8*k+b]);
      end
    if (crc_two_i) begin
      c = 16'hFFFF;
      foreach (d[i]) begin
        fb = c[15] ^ d[i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
      for (int i = 15; i >= 0; i--) begin q.push_back(c[i]); tq.push_back("R6"); end
    end else begin
      c = 16'h00FF;
      foreach (d[i]) begin
        fb = c[7] ^ d[i];
        c[7:0] = {c[6:0], 1'b0};
        if (fb) c[7:0] = c[7:0] ^ 8'h07;
      end
      for (int i = 7; i >= 0; i--) begin q.push_back(c[i]); tq.push_back("R7"); end
    end
  endtask

  task automatic check(input string idle_tag);
    bit ev;
    ev = (q.size() > 0);
    nchk++;
    if (valid_o !== ev) begin
      nfail++;
      $display("FAIL %s valid: actual=%b expected=%b", ign ? "R9" : "R1", valid_o, ev);
    end else if (ev && bit_o !== q[0]) begin
      nfail++;
      $display("FAIL %s bit: actual=%b expected=%b", tq[0], bit_o, q[0]);
    end else if (done_o !== (q.size() == 1)) begin
      nfail++;
      $display("FAIL R8 done: actual=%b expected=%b", done_o, q.size() == 1);
    end else if (!ev && bit_o !== 1'b0) begin
      nfail++;
      $display("FAIL %s idle bit: actual=%b expected=0", idle_tag, bit_o);
    end
  endtask

  // One clock: model consumes the current bit, takes a start only when idle (R1, R9)
  task automatic cycle();
    bit was_idle;
    was_idle = (q.size() == 0);
    accepted = 0;
    if (!was_idle) begin void'(q.pop_front()); void'(tq.pop_front()); end
    if (start_i && rst_n && was_idle) begin build(); ign = 0; accepted = 1; end
    else if (start_i && !was_idle) ign = 1;
    @(negedge clk);
    check("R10");
  endtask

  task automatic set_fields(input int ab, input int ln, input logic [1:0] p,
                            input bit na, input bit c2, input bit top1);
    addr_bytes_i = 3'(ab);
    len_i        = 6'(ln);
    pid_i        = p;
    no_ack_i     = na;
    crc_two_i    = c2;
    for (int i = 0; i < AM; i++) addr_i[8*i +: 8] = 8'($urandom);
    for (int i = 0; i < PM; i++) payload_i[8*i +: 8] = 8'($urandom);
    begin
      int a;
      a = (ab < 3) ? 3 : (ab > 5) ? 5 : ab;
      addr_i[8*a-1] = top1;
    end
  endtask

  task automatic send(input bit noisy);
    start_i = 1'b1;
    do cycle(); while (!accepted);
    start_i = 1'b0;
    while (q.size() > 0) begin
      if (noisy) begin
        // R9: stray strobes and changing inputs mid-frame, including on the last bit
        start_i = (q.size() % 7 == 0) || (q.size() == 1);
        set_fields(int'($urandom_range(0, 7)), int'($urandom_range(0, 63)),
                   2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      cycle();
    end
    start_i = 1'b0;
    cycle();
  endtask

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    set_fields(5, 4, 2'd2, 1'b0, 1'b1, 1'b1);
    // R10: reset state
    repeat (3) begin @(negedge clk); check("R10"); end
    rst_n = 1'b1;
    repeat (2) cycle();

    set_fields(5, 4, 2'd2, 1'b0, 1'b1, 1'b1); send(0);   // R6, R2 0xAA
    set_fields(3, 0, 2'd1, 1'b1, 1'b0, 1'b0); send(0);   // R5 empty, R7, R2 0x55
    set_fields(4, 32, 2'd3, 1'b0, 1'b1, 1'b0); send(0);  // R5 full payload
    set_fields(7, 45, 2'd0, 1'b1, 1'b0, 1'b1); send(0);  // R3 and R4 clamping
    set_fields(1, 9, 2'd1, 1'b0, 1'b1, 1'b1); send(0);   // R3 lower clamp
    set_fields(5, 12, 2'd2, 1'b1, 1'b1, 1'b0); send(1);  // R9 stray starts

    // R1: strobe held high gives frames with one idle cycle between them
    set_fields(3, 2, 2'd0, 1'b0, 1'b0, 1'b1);
    start_i = 1'b1;
    repeat (3 * (8 + 24 + 9 + 16 + 8) + 6) cycle();
    start_i = 1'b0;
    while (q.size() > 0) cycle();
    cycle();

    for (int n = 0; n < 24; n++) begin
      set_fields(int'($urandom_range(0, 7)), int'($urandom_range(0, 40)),
                 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      send(n % 3 == 0);
    end
    repeat (4) cycle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule